// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block lets a clocked host read and write an external asynchronous static RAM of 32K words by 16 bits. The host hands over one access at a time on a valid/ready request channel: a 15-bit word address, 16 bits of write data, a write flag and one enable bit per byte lane. The controller answers with a one-cycle response strobe that carries the read data.

On the memory side the controller drives the chip select (active high), the active-low output, write and per-lane byte strobes, and the address. The 16-bit bidirectional data bus is presented as separate out, in and drive-enable signals, so a pad ring can build the tri-state buffer. The length of every strobe phase is a number of clock cycles. Each count is worked out at elaboration from the memory's nanosecond figures and the clock period: the figure divided by the period and rounded up, and never less than one cycle.

Back-pressure: a request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so the host holds its request fields steady until that edge. The response strobe cannot be stalled: the host must take `rsp_rdata` in the cycle `rsp_valid` is high.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no request, `mem_ce` is 0, `mem_oe_n`, `mem_we_n`, `mem_lb_n` and `mem_ub_n` are 1, `mem_dq_oe` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: A request is taken on an edge with `req_valid` and `req_ready` both high. `req_ready` then stays low until its response, during the response cycle, and during one further turnaround cycle. It returns high in the cycle after that.
- R3: A write drives `mem_ce`=1, `mem_oe_n`=1 and `mem_we_n`=0. It holds `mem_dq_oe` low for the first HZ cycles (bus release time), then high for DRV cycles. In the response cycle `mem_we_n` returns to 1 and `mem_dq_oe` falls in that same cycle, while `mem_ce` is still 1.
- R4: Request lane bit 0 enables data bits 7:0 (strobe `mem_lb_n`), and lane bit 1 enables bits 15:8 (strobe `mem_ub_n`). A write changes only the bytes of enabled lanes.
- R5: A read drives `mem_ce`=1, `mem_oe_n`=0 and `mem_we_n`=1 for RD cycles, where RD is the largest of the address, output-enable and byte-enable access counts. `mem_dq_in` is registered at the end of the last of those cycles. Read and write strobes are never low together, and every strobe stays inactive while `mem_ce` is 0.
- R6: In the read response, the byte of a disabled lane reads as zero.
- R7: `rsp_valid` is high for exactly one cycle per request. For a read, `rsp_rdata` holds the read word in that cycle.
- R8: A request with both lane bits clear keeps both byte strobes high for its whole duration, leaves memory unchanged, and, for a read, returns zero.
- R9: Counting from the accepting edge, `rsp_valid` rises in cycle RD+1 for a read and in cycle HZ+DRV+1 for a write. Here HZ = ceil(T_HIZ/period), DRV = max(ceil(T_DSETUP/period), ceil(T_WPULSE/period) - HZ, 1), and every count is at least 1.
- R10: `mem_addr` and the byte strobes stay stable while `mem_ce` remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request may transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Byte-lane enables, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 16 | Read data |
| mem_ce | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte strobe, active low |
| mem_ub_n | output | 1 | High byte strobe, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_in | input | 16 | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The properties assume that the host changes its request fields only while no transfer is in progress, and that reset is held for at least one edge before the first request. The directed stimulus keeps to this. It raises a request only at a falling edge, drops `req_valid` right after the accepting edge, and never moves the fields while a request waits. The properties also assume that `mem_dq_in` is meaningful only while `mem_oe_n` is low. The bench's memory model returns a poison word until the access time has run out, so a capture made too early shows up as a wrong read value.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_DONE,
    ST_WR_SETUP,
    ST_WR_DRIVE,
    ST_WR_DONE,
    ST_TURN
  } seq_state_e;

  // nanoseconds to whole clock cycles, rounded up, at least one
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC  = 2,
  parameter int unsigned HZ_CYC  = 1,
  parameter int unsigned DRV_CYC = 1,
  parameter int unsigned CW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_write,
  input  logic          expired,
  output seq_state_e    state,
  output logic          tload,
  output logic [CW-1:0] tval
);
  seq_state_e nxt;

  always_comb begin
    nxt   = state;
    tload = 1'b0;
    tval  = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        tload = 1'b1;
        if (is_write) begin
          tval = CW'(HZ_CYC - 1);
          nxt  = ST_WR_SETUP;
        end else begin
          tval = CW'(RD_CYC - 1);
          nxt  = ST_RD_ACC;
        end
      end
      ST_RD_ACC:   if (expired) nxt = ST_RD_DONE;
      ST_RD_DONE:  nxt = ST_TURN;
      ST_WR_SETUP: if (expired) begin
        tload = 1'b1;
        tval  = CW'(DRV_CYC - 1);
        nxt   = ST_WR_DRIVE;
      end
      ST_WR_DRIVE: if (expired) nxt = ST_WR_DONE;
      ST_WR_DONE:  nxt = ST_TURN;
      ST_TURN:     nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned LANE_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_ACCESS_NS   = 12,
  parameter int unsigned T_OE_DATA_NS  = 6,
  parameter int unsigned T_BE_DATA_NS  = 6,
  parameter int unsigned T_WPULSE_NS   = 8,
  parameter int unsigned T_DSETUP_NS   = 6,
  parameter int unsigned T_HIZ_NS      = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*LANE_W-1:0] req_wdata,
  input  logic [1:0]          req_lanes,
  output logic                rsp_valid,
  output logic [2*LANE_W-1:0] rsp_rdata,
  output logic                mem_ce,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic                mem_lb_n,
  output logic                mem_ub_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [2*LANE_W-1:0] mem_dq_out,
  input  logic [2*LANE_W-1:0] mem_dq_in,
  output logic                mem_dq_oe
);
  localparam int unsigned LANES   = 2;
  localparam int unsigned DATA_W  = LANES * LANE_W;
  localparam int unsigned HZ_CYC  = ns_to_cyc(T_HIZ_NS, CLK_PERIOD_NS);
  localparam int unsigned RD_CYC  = max2(ns_to_cyc(T_ACCESS_NS, CLK_PERIOD_NS),
                                    max2(ns_to_cyc(T_OE_DATA_NS, CLK_PERIOD_NS),
                                         ns_to_cyc(T_BE_DATA_NS, CLK_PERIOD_NS)));
  localparam int unsigned WPW_CYC = ns_to_cyc(T_WPULSE_NS, CLK_PERIOD_NS);
  localparam int unsigned DRV_CYC = max2(ns_to_cyc(T_DSETUP_NS, CLK_PERIOD_NS),
                                    (WPW_CYC > HZ_CYC) ? WPW_CYC - HZ_CYC : 1);
  localparam int unsigned MAX_CYC = max2(RD_CYC, max2(HZ_CYC, DRV_CYC));
  localparam int unsigned CW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  seq_state_e        state;
  logic              tload, expired, accept, active;
  logic [CW-1:0]     tval;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [LANES-1:0]  lane_q, ben_n;
  logic              write_q;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  sram_seq #(
    .RD_CYC(RD_CYC), .HZ_CYC(HZ_CYC), .DRV_CYC(DRV_CYC), .CW(CW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .is_write(req_write),
    .expired(expired), .state(state), .tload(tload), .tval(tval)
  );

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tload), .load_val(tval), .expired(expired)
  );

  // request registers, loaded only on transfer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      lane_q  <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      lane_q  <= req_lanes;
      write_q <= req_write;
    end
  end

  assign active = (state == ST_RD_ACC) || (state == ST_WR_SETUP) ||
                  (state == ST_WR_DRIVE) || (state == ST_WR_DONE);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign ben_n[l] = !(active && lane_q[l]);
    // capture on the final access cycle, still under CE and OE
    always_ff @(posedge clk) begin
      if (!rst_n)
        rdata_q[l*LANE_W +: LANE_W] <= '0;
      else if (state == ST_RD_ACC && expired && !write_q)
        rdata_q[l*LANE_W +: LANE_W] <= lane_q[l] ? mem_dq_in[l*LANE_W +: LANE_W] : '0;
    end
  end

  assign mem_ce     = active;
  assign mem_oe_n   = (state != ST_RD_ACC);
  assign mem_we_n   = !((state == ST_WR_SETUP) || (state == ST_WR_DRIVE));
  assign mem_dq_oe  = (state == ST_WR_DRIVE);
  assign mem_lb_n   = ben_n[0];
  assign mem_ub_n   = ben_n[1];
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rsp_valid  = (state == ST_RD_DONE) || (state == ST_WR_DONE);
  assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe
);
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_turnaround_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !req_ready);

  assert_drive_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_ce && !mem_we_n && mem_oe_n));

  assert_drive_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(!mem_we_n && mem_ce));

  assert_drop_with_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> ($rose(mem_we_n) && mem_ce));

  assert_no_rw_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_strobes_need_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce |-> (mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n));

  assert_single_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ce && $past(mem_ce)) |-> ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;
  localparam int CLK_PERIOD = 10;
  // expected cycle counts from the requirement formulas, 10 ns clock
  function automatic int cyc(int ns);
    int c;
    c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int HZ  = cyc(6);
  localparam int RD  = (cyc(12) > cyc(6)) ? cyc(12) : cyc(6);
  localparam int DRV = (cyc(6) > ((cyc(8) > HZ) ? cyc(8) - HZ : 1)) ? cyc(6)
                       : ((cyc(8) > HZ) ? cyc(8) - HZ : 1);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [14:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_lanes = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic mem_ce, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [14:0] mem_addr;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_ctrl i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_lanes(req_lanes), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce(mem_ce), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // small memory model, indexed by the low address byte
  logic [15:0] mdl [256];
  int acc;
  initial for (int i = 0; i < 256; i++) mdl[i] = '0;
  always @(posedge clk) begin
    if (mem_ce && !mem_we_n && mem_dq_oe) begin
      if (!mem_lb_n) mdl[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_ub_n) mdl[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
    end
    acc <= (mem_ce && !mem_oe_n) ? acc + 1 : 0;
  end
  initial acc = 0;
  always_comb begin
    if (mem_ce && !mem_oe_n && mem_we_n && acc >= RD - 1)
      mem_dq_in = {mem_ub_n ? 8'hA5 : mdl[mem_addr[7:0]][15:8],
                   mem_lb_n ? 8'h5A : mdl[mem_addr[7:0]][7:0]};
    else
      mem_dq_in = 16'hDEAD;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bus conflict monitor
  always @(negedge clk) if (rst_n && mem_dq_oe && !mem_oe_n) begin
    checks++; fails++;
    $display("FAIL R3: drive while memory outputs on, actual 1 expected 0");
  end

  task automatic run_req(input logic wr, input logic [14:0] a, input logic [15:0] d,
                         input logic [1:0] ln, output logic [15:0] rd);
    int n;
    int lat;
    lat = wr ? HZ + DRV + 1 : RD + 1;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_lanes = ln;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    n = 1;
    while (!rsp_valid && n < 40) begin
      // {ce, oe_n, we_n, dq_oe, lb_n, ub_n}
      check(wr ? "R3/R4 write strobes" : "R5/R4 read strobes",
            {mem_ce, mem_oe_n, mem_we_n, mem_dq_oe, mem_lb_n, mem_ub_n},
            {1'b1, wr, !wr, wr && (n > HZ), !ln[0], !ln[1]});
      check("R2 busy", req_ready, 0);
      @(negedge clk);
      n++;
    end
    check("R9 latency", n, lat);
    if (wr) check("R3 write end", {mem_ce, mem_we_n, mem_dq_oe}, 3'b110);
    else    check("R5 read end",  {mem_ce, mem_oe_n}, 2'b01);
    rd = rsp_rdata;
    @(negedge clk);
    check("R7 single ack", rsp_valid, 0);
    check("R2 turnaround", req_ready, 0);
    @(negedge clk);
    check("R2 ready again", req_ready, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset", {mem_ce, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, rsp_valid},
          7'b0111100);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle", {req_ready, mem_ce, mem_dq_oe, rsp_valid}, 4'b1000);
  endtask

  task automatic t_full_word();
    logic [15:0] r;
    run_req(1, 15'h0011, 16'h1234, 2'b11, r);
    run_req(0, 15'h0011, 16'h0000, 2'b11, r);
    check("R7 read word", r, 16'h1234);
    run_req(1, 15'h7F22, 16'hBEEF, 2'b11, r);
    run_req(0, 15'h7F22, 16'h0000, 2'b11, r);
    check("R7 read word high addr", r, 16'hBEEF);
  endtask

  task automatic t_lanes();
    logic [15:0] r;
    run_req(1, 15'h0005, 16'h1234, 2'b11, r);
    run_req(1, 15'h0005, 16'hFFAB, 2'b01, r);
    run_req(0, 15'h0005, 16'h0000, 2'b11, r);
    check("R4 low lane write", r, 16'h12AB);
    run_req(1, 15'h0005, 16'hCD00, 2'b10, r);
    run_req(0, 15'h0005, 16'h0000, 2'b11, r);
    check("R4 high lane write", r, 16'hCDAB);
    run_req(0, 15'h0005, 16'h0000, 2'b01, r);
    check("R6 low lane read", r, 16'h00AB);
    run_req(0, 15'h0005, 16'h0000, 2'b10, r);
    check("R6 high lane read", r, 16'hCD00);
  endtask

  task automatic t_no_lane();
    logic [15:0] r;
    run_req(1, 15'h0005, 16'h7777, 2'b00, r);
    run_req(0, 15'h0005, 16'h0000, 2'b11, r);
    check("R8 no-lane write keeps memory", r, 16'hCDAB);
    run_req(0, 15'h0005, 16'h0000, 2'b00, r);
    check("R8 no-lane read zero", r, 16'h0000);
  endtask

  task automatic t_alternate();
    logic [15:0] r;
    for (int i = 0; i < 4; i++) begin
      run_req(1, 15'(8'h40 + i), 16'(16'h1111 * (i + 1)), 2'b11, r);
      run_req(0, 15'(8'h40 + i), 16'h0000, 2'b11, r);
      check("R7 alternate read back", r, 16'(16'h1111 * (i + 1)));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_full_word();
    t_lanes();
    t_no_lane();
    t_alternate();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule